// File: doc/BRIEF.md
# IQ Sample Stream Serializer

This block takes the two-bit sign/magnitude codes of an I and a Q converter sample, gathers them into 16-bit words and shifts those words out one bit per clock. Alongside the bit line it drives a bit qualifier that serves as the serial clock, a word-start strobe, a frame-start strobe and a periodic time-mark strobe. Software-style control levels decide whether the path is in use, when streaming runs, which sample bits are taken, whether each frame opens with a running frame number, which strobes appear and when the counters are cleared.

Streaming is started and halted by rising edges on two command levels, so a command bit left high does nothing more. A frame is a fixed number of words. When frame numbering is on, the first word of every frame carries the frame count, zero-extended to 16 bits and sent most significant bit first. The time-mark strobe comes from a free-running count of sample strobes. It can be shown whenever the path is enabled, or only while streaming runs.

Top module: `iq_stream_ser`

## Requirements
- R1: While `if_en` is low, all five outputs are low from the next clock. Streaming is cancelled and must be restarted by a fresh rising edge of `start_cmd`.
- R2: A rising edge of `start_cmd`, seen while `if_en` is high, starts streaming. Holding `start_cmd` high after a stop does not restart it.
- R3: A rising edge of `stop_cmd` ends streaming from that clock on. It discards any partly sent or partly packed word and resets the word position, so the next start opens a new frame. If both edges arrive in the same clock, the stop wins.
- R4: With `mode` = 1, each sample strobe appends I sign then I magnitude (`i_bits[1]`, `i_bits[0]`). Eight samples make one word, and the first bit taken is sent first.
- R5: With `mode` = 3, each sample strobe appends `i_bits[1]`, `i_bits[0]`, `q_bits[1]`, `q_bits[0]` in that order. Four samples make one word.
- R6: Codes 0 and 2 of `mode` pack nothing and produce no data words. Any change of `mode` discards the partly packed word.
- R7: A frame is FRAME_WORDS words. `fsync` is high for exactly the first bit of the first word of each frame. With `fnum_en` high, that first word is the frame number, zero-extended and sent MSB first.
- R8: The frame number starts at 0, rises by one each time the last word of a frame is loaded, and wraps from all ones (FNUM_W bits) to 0.
- R9: With `fnum_en` low at a frame start, the frame holds data words only.
- R10: With `dsync_en` high, `dsync` is high for the first bit of every word. With it low, `dsync` stays low.
- R11: `tsync` pulses for one clock on every TSYNC_PERIOD-th sample strobe. It appears at any time `if_en` is high when `tsync_en` is high, and only while streaming runs when `tsync_en` is low.
- R12: While `cnt_rst` is high, the bit, word, frame-number, packing and time-mark counters are held at zero and nothing is sent. Streaming state is kept, and after release the next frame carries number 0.
- R13: Outputs are registered, one bit per clock. A following word starts on the clock right after the sixteenth bit of the current one, whenever that word is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Path enable; low bypasses the block |
| start_cmd | input | 1 | Start command, acts on its rising edge |
| stop_cmd | input | 1 | Stop command, acts on its rising edge |
| mode | input | 2 | Bit selection code: 1 = I only, 3 = I and Q, 0/2 = none |
| fnum_en | input | 1 | Insert frame number as first word of each frame |
| tsync_en | input | 1 | Time-mark strobe shown whenever enabled, not only while streaming |
| dsync_en | input | 1 | Enables word-start strobe |
| cnt_rst | input | 1 | Holds all counters at zero while high |
| samp_vld | input | 1 | One-clock strobe marking a new sample |
| i_bits | input | 2 | I sample: [1] sign, [0] magnitude |
| q_bits | input | 2 | Q sample: [1] sign, [0] magnitude |
| ser_clk | output | 1 | High on every clock that carries a valid bit |
| ser_dat | output | 1 | Serial data, MSB of each word first |
| dsync | output | 1 | First bit of a word |
| fsync | output | 1 | First bit of a frame |
| tsync | output | 1 | Periodic time-mark pulse |

## Verification
The hardest case to reach is a clear in the middle of a frame. It needs `cnt_rst` or a stop edge to land while a word is half shifted out, a second word is waiting and the packer holds a partial word, and the next frame must then still line up. The stimulus runs long streams in both bit modes, with sample strobes spaced so that frame-number words and data words queue behind each other. It also toggles the mode between valid and reserved codes partway through a word, then holds `cnt_rst` across a sample strobe during a busy frame. The frame count width is cut down in the bench so the number wraps several times within one run.

// File: rtl/iq_stream_pkg.sv
package iq_stream_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    MODE_RSV0 = 2'd0,
    MODE_I    = 2'd1,
    MODE_RSV2 = 2'd2,
    MODE_IQ   = 2'd3
  } smode_e;

  // a code that actually selects sample bits
  function automatic logic mode_is_valid(input logic [1:0] m);
    return (smode_e'(m) == MODE_I) || (smode_e'(m) == MODE_IQ);
  endfunction

  // bits appended per sample strobe
  function automatic logic [2:0] bits_per_sample(input logic [1:0] m);
    case (smode_e'(m))
      MODE_I:  return 3'd2;
      MODE_IQ: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // shift the new sample bits in at the bottom; first bit in leaves first
  function automatic logic [WORD_W-1:0] pack_append(input logic [WORD_W-1:0] acc,
                                                    input logic [1:0] m,
                                                    input logic [1:0] ib,
                                                    input logic [1:0] qb);
    if (smode_e'(m) == MODE_IQ) return {acc[WORD_W-5:0], ib, qb};
    return {acc[WORD_W-3:0], ib};
  endfunction

endpackage

// File: rtl/iq_cmd_ctrl.sv
module iq_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  logic start_cmd,
  input  logic stop_cmd,
  output logic start_rise,
  output logic stop_rise,
  output logic active_nxt,
  output logic active_q
);
  logic start_q, stop_q;

  assign start_rise = start_cmd & ~start_q;
  assign stop_rise  = stop_cmd & ~stop_q;

  always_comb begin
    if (!if_en || stop_rise) active_nxt = 1'b0;
    else if (start_rise)     active_nxt = 1'b1;
    else                     active_nxt = active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      start_q  <= start_cmd;
      stop_q   <= stop_cmd;
      active_q <= active_nxt;
    end
  end
endmodule

// File: rtl/iq_packer.sv
module iq_packer
  import iq_stream_pkg::*;
#(
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [1:0]    mode,
  input  logic          samp_vld,
  input  logic [1:0]    i_bits,
  input  logic [1:0]    q_bits,
  input  logic          take,
  output logic          hold_vld,
  output logic [WW-1:0] hold_word,
  output logic          pack_done
);
  localparam int FILL_W = $clog2(WW) + 1;

  logic [1:0]        mode_q;
  logic [WW-1:0]     acc, acc_nxt;
  logic [FILL_W-1:0] fill, fill_base, fill_sum;
  logic              pack_fire;

  assign fill_base = (mode != mode_q) ? '0 : fill;
  assign pack_fire = samp_vld & mode_is_valid(mode) & ~clr;
  assign fill_sum  = fill_base + FILL_W'(bits_per_sample(mode));
  assign acc_nxt   = pack_append(acc, mode, i_bits, q_bits);
  assign pack_done = pack_fire && (fill_sum == FILL_W'(WW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 2'd0;
      acc       <= '0;
      fill      <= '0;
      hold_vld  <= 1'b0;
      hold_word <= '0;
    end else begin
      mode_q <= mode;
      if (clr) begin
        fill     <= '0;
        hold_vld <= 1'b0;
      end else begin
        if (pack_fire) begin
          acc  <= acc_nxt;
          fill <= pack_done ? '0 : fill_sum;
        end else begin
          fill <= fill_base;
        end
        if (pack_done) begin
          hold_vld  <= 1'b1;
          hold_word <= acc_nxt;
        end else if (take) begin
          hold_vld <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/iq_frame_ser.sv
module iq_frame_ser
  import iq_stream_pkg::*;
#(
  parameter int WW          = WORD_W,
  parameter int FRAME_WORDS = 8,
  parameter int FNUM_W      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_stream,
  input  logic          clr_cnt,
  input  logic          fnum_en,
  input  logic          dsync_en,
  input  logic          hold_vld,
  input  logic [WW-1:0] hold_word,
  output logic          take,
  output logic          word_load,
  output logic          ser_clk,
  output logic          ser_dat,
  output logic          dsync,
  output logic          fsync
);
  localparam int REM_W  = $clog2(WW);
  localparam int WIDX_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(FRAME_WORDS - 1);

  logic [REM_W-1:0]  rem;
  logic [WW-1:0]     sh, fnum_word, word_sel;
  logic [WIDX_W-1:0] widx;
  logic [FNUM_W-1:0] fnum;
  logic              clr, shifting, at_head, insert;

  assign clr       = clr_stream | clr_cnt;
  assign shifting  = (rem != '0);
  assign at_head   = (widx == '0);
  assign insert    = at_head & fnum_en;
  assign word_load = ~clr & ~shifting & (insert | hold_vld);
  assign take      = word_load & ~insert;

  always_comb begin
    fnum_word = '0;
    fnum_word[FNUM_W-1:0] = fnum;
  end

  assign word_sel = insert ? fnum_word : hold_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      sh      <= '0;
      widx    <= '0;
      fnum    <= '0;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
      dsync   <= 1'b0;
      fsync   <= 1'b0;
    end else if (clr) begin
      rem     <= '0;
      widx    <= '0;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
      dsync   <= 1'b0;
      fsync   <= 1'b0;
      if (clr_cnt) fnum <= '0;
    end else if (shifting) begin
      ser_clk <= 1'b1;
      ser_dat <= sh[WW-1];
      sh      <= sh << 1;
      rem     <= rem - 1'b1;
      dsync   <= 1'b0;
      fsync   <= 1'b0;
    end else if (word_load) begin
      ser_clk <= 1'b1;
      ser_dat <= word_sel[WW-1];
      sh      <= word_sel << 1;
      rem     <= REM_W'(WW - 1);
      dsync   <= dsync_en;
      fsync   <= at_head;
      if (widx == LAST_IDX) begin
        widx <= '0;
        fnum <= fnum + 1'b1;
      end else begin
        widx <= widx + 1'b1;
      end
    end else begin
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
      dsync   <= 1'b0;
      fsync   <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_tsync_gen.sv
module iq_tsync_gen #(
  parameter int TSYNC_PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic if_en,
  input  logic cnt_rst,
  input  logic samp_vld,
  input  logic tsync_en,
  input  logic active_nxt,
  output logic tick,
  output logic tsync
);
  localparam int TC_W = (TSYNC_PERIOD > 1) ? $clog2(TSYNC_PERIOD) : 1;
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TSYNC_PERIOD - 1);

  logic [TC_W-1:0] tcnt;

  assign tick = if_en & ~cnt_rst & samp_vld & (tcnt == TC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      tsync <= 1'b0;
    end else begin
      if (!if_en || cnt_rst) tcnt <= '0;
      else if (samp_vld)     tcnt <= tick ? '0 : tcnt + 1'b1;
      tsync <= tick & (tsync_en | active_nxt);
    end
  end
endmodule

// File: rtl/iq_stream_ser.sv
module iq_stream_ser
  import iq_stream_pkg::*;
#(
  parameter int FRAME_WORDS  = 8,
  parameter int TSYNC_PERIOD = 1000,
  parameter int FNUM_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       if_en,
  input  logic       start_cmd,
  input  logic       stop_cmd,
  input  logic [1:0] mode,
  input  logic       fnum_en,
  input  logic       tsync_en,
  input  logic       dsync_en,
  input  logic       cnt_rst,
  input  logic       samp_vld,
  input  logic [1:0] i_bits,
  input  logic [1:0] q_bits,
  output logic       ser_clk,
  output logic       ser_dat,
  output logic       dsync,
  output logic       fsync,
  output logic       tsync
);
  logic              start_rise, stop_rise, active_nxt, stream_active;
  logic              pack_done, hold_vld, take, word_load, ts_tick;
  logic [WORD_W-1:0] hold_word;

  iq_cmd_ctrl u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_en      (if_en),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .start_rise (start_rise),
    .stop_rise  (stop_rise),
    .active_nxt (active_nxt),
    .active_q   (stream_active)
  );

  iq_packer #(.WW(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (~active_nxt | cnt_rst),
    .mode      (mode),
    .samp_vld  (samp_vld),
    .i_bits    (i_bits),
    .q_bits    (q_bits),
    .take      (take),
    .hold_vld  (hold_vld),
    .hold_word (hold_word),
    .pack_done (pack_done)
  );

  iq_frame_ser #(
    .WW          (WORD_W),
    .FRAME_WORDS (FRAME_WORDS),
    .FNUM_W      (FNUM_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_stream (~active_nxt),
    .clr_cnt    (cnt_rst),
    .fnum_en    (fnum_en),
    .dsync_en   (dsync_en),
    .hold_vld   (hold_vld),
    .hold_word  (hold_word),
    .take       (take),
    .word_load  (word_load),
    .ser_clk    (ser_clk),
    .ser_dat    (ser_dat),
    .dsync      (dsync),
    .fsync      (fsync)
  );

  iq_tsync_gen #(.TSYNC_PERIOD(TSYNC_PERIOD)) u_ts (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_en      (if_en),
    .cnt_rst    (cnt_rst),
    .samp_vld   (samp_vld),
    .tsync_en   (tsync_en),
    .active_nxt (active_nxt),
    .tick       (ts_tick),
    .tsync      (tsync)
  );
endmodule

// File: rtl/iq_stream_ser_chk.sv
module iq_stream_ser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_en,
  input logic       cnt_rst,
  input logic [1:0] mode,
  input logic       dsync_en,
  input logic       tsync_en,
  input logic       ser_clk,
  input logic       dsync,
  input logic       fsync,
  input logic       tsync,
  input logic       stop_rise,
  input logic       start_rise,
  input logic       stream_active,
  input logic       pack_done,
  input logic       word_load,
  input logic       ts_tick
);
  // R1: disabled path is silent on the next clock
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> (!ser_clk && !dsync && !fsync && !tsync));

  // R3: a stop edge halts output and clears streaming
  a_r3_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    stop_rise |=> (!ser_clk && !stream_active));

  // R2: a start edge with the path enabled and no stop leaves streaming on
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && if_en && !stop_rise) |=> stream_active);

  // R6: reserved codes never complete a word
  a_r6_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b10) |-> !pack_done);

  // R7: frame strobe only rides on a valid bit
  a_r7_fsync_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> ser_clk);

  // R10: word strobe only on a valid bit and only when enabled
  a_r10_dsync_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dsync |-> (ser_clk && $past(dsync_en)));

  // R11: with the enable clear, a time mark implies streaming
  a_r11_tsync_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tsync && !$past(tsync_en)) |-> stream_active);

  // R11: every time mark comes from a period tick
  a_r11_tsync_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tsync |-> $past(ts_tick));

  // R12: counter clear silences output and loads nothing
  a_r12_cnt_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> (!ser_clk && !tsync));

  a_r12_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> !word_load);
endmodule

bind iq_stream_ser iq_stream_ser_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .if_en         (if_en),
  .cnt_rst       (cnt_rst),
  .mode          (mode),
  .dsync_en      (dsync_en),
  .tsync_en      (tsync_en),
  .ser_clk       (ser_clk),
  .dsync         (dsync),
  .fsync         (fsync),
  .tsync         (tsync),
  .stop_rise     (stop_rise),
  .start_rise    (start_rise),
  .stream_active (stream_active),
  .pack_done     (pack_done),
  .word_load     (word_load),
  .ts_tick       (ts_tick)
);

// File: tb/iq_stream_ser_tb.sv
module iq_stream_ser_tb;
  localparam int FW = 3;
  localparam int TP = 4;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en = 0, start_cmd = 0, stop_cmd = 0, fnum_en = 0;
  logic tsync_en = 0, dsync_en = 0, cnt_rst = 0, samp_vld = 0;
  logic [1:0] mode = 2'd0, i_bits = 2'd0, q_bits = 2'd0;
  logic ser_clk, ser_dat, dsync, fsync, tsync;

  always #4 clk = ~clk;

  iq_stream_ser #(.FRAME_WORDS(FW), .TSYNC_PERIOD(TP), .FNUM_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .mode(mode), .fnum_en(fnum_en), .tsync_en(tsync_en),
    .dsync_en(dsync_en), .cnt_rst(cnt_rst), .samp_vld(samp_vld),
    .i_bits(i_bits), .q_bits(q_bits), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dsync(dsync), .fsync(fsync), .tsync(tsync)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0, n_fs = 0;
  string phase = "R13 reset";
  bit    done = 0;

  // ---------------- behavioural reference ----------------
  logic [15:0] wq[$];
  logic [15:0] m_sh, m_acc, w;
  int  m_rem, m_wcnt, m_fnum, m_tcnt, m_fill;
  bit  m_start_q, m_stop_q, m_act;
  logic [1:0] m_mode_q;
  logic [4:0] exp_o;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); m_rem = 0; m_wcnt = 0; m_fnum = 0; m_tcnt = 0; m_fill = 0;
      m_start_q = 0; m_stop_q = 0; m_act = 0; m_mode_q = 2'd0; m_sh = '0; m_acc = '0;
      exp_o = '0;
    end else begin
      bit sr, pr, ts, oc, od, ods, ofs;
      sr = start_cmd && !m_start_q;
      pr = stop_cmd && !m_stop_q;
      m_start_q = start_cmd; m_stop_q = stop_cmd;
      if (!if_en || pr) m_act = 0;
      else if (sr) m_act = 1;
      ts = 0;
      if (!if_en || cnt_rst) m_tcnt = 0;
      else if (samp_vld) begin
        if (m_tcnt == TP - 1) begin m_tcnt = 0; ts = tsync_en || m_act; end
        else m_tcnt++;
      end
      oc = 0; od = 0; ods = 0; ofs = 0;
      if (!m_act || cnt_rst) begin
        m_rem = 0; m_wcnt = 0; m_fill = 0; wq.delete();
        if (cnt_rst) m_fnum = 0;
      end else begin
        if (m_rem > 0) begin
          oc = 1; od = m_sh[15]; m_sh = m_sh << 1; m_rem--;
        end else if ((m_wcnt == 0 && fnum_en) || wq.size() > 0) begin
          if (m_wcnt == 0 && fnum_en) w = 16'(m_fnum);
          else w = wq.pop_front();
          oc = 1; od = w[15]; m_sh = w << 1; m_rem = 15;
          ods = dsync_en; ofs = (m_wcnt == 0);
          m_wcnt++;
          if (m_wcnt == FW) begin m_wcnt = 0; m_fnum = (m_fnum + 1) % (1 << NW); end
        end
        if (mode != m_mode_q) m_fill = 0;
        if (samp_vld && (mode == 2'd1 || mode == 2'd3)) begin
          if (mode == 2'd3) begin m_acc = {m_acc[11:0], i_bits, q_bits}; m_fill += 4; end
          else begin m_acc = {m_acc[13:0], i_bits}; m_fill += 2; end
          if (m_fill == 16) begin wq.push_back(m_acc); m_fill = 0; end
        end
      end
      m_mode_q = mode;
      exp_o = {oc, od, ods, ofs, ts};
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if ({ser_clk, ser_dat, dsync, fsync, tsync} !== exp_o) begin
        n_fail++;
        $display("FAIL %s cyc=%0d act clk/dat/ds/fs/ts=%b exp=%b",
                 phase, cyc, {ser_clk, ser_dat, dsync, fsync, tsync}, exp_o);
      end
      if (fsync) n_fs++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_samples(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      samp_vld = 1'b1; i_bits = 2'($urandom); q_bits = 2'($urandom);
      @(negedge clk);
      samp_vld = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  initial begin
    int fs0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ser_clk, dsync, fsync, tsync} == 4'b0, "R13 reset state", int'({ser_clk, dsync, fsync, tsync}), 0);

    phase = "R1 interface off";
    tsync_en = 1; mode = 2'd3; start_cmd = 1;
    run_samples(6);
    start_cmd = 0;

    phase = "R11 time mark gated by streaming";
    if_en = 1; tsync_en = 0;
    run_samples(10);
    phase = "R11 time mark ungated";
    tsync_en = 1;
    run_samples(8);

    phase = "R2 R4 start edge, I-only packing";
    tsync_en = 0; mode = 2'd1; fnum_en = 1; dsync_en = 1;
    @(negedge clk); start_cmd = 1;
    fs0 = n_fs;
    run_samples(50);
    chk(n_fs > fs0, "R2 streaming began", n_fs - fs0, 1);

    phase = "R3 R2 stop edge, start level held";
    @(negedge clk); stop_cmd = 1;
    fs0 = n_fs;
    run_samples(12);
    chk(n_fs == fs0, "R2 held start level no restart", n_fs - fs0, 0);
    stop_cmd = 0; start_cmd = 0;
    idle(2);

    phase = "R5 R8 R13 I/Q packing, frame count wrap";
    mode = 2'd3; tsync_en = 1;
    @(negedge clk); start_cmd = 1;
    @(negedge clk); start_cmd = 0;
    fs0 = n_fs;
    run_samples(110);
    chk(n_fs - fs0 > (1 << NW), "R8 frames beyond wrap", n_fs - fs0, (1 << NW) + 1);

    phase = "R9 R10 no frame number, no word strobe";
    fnum_en = 0; dsync_en = 0;
    run_samples(30);

    phase = "R6 reserved codes and mode change";
    mode = 2'd2; run_samples(10);
    mode = 2'd0; run_samples(5);
    mode = 2'd3; run_samples(2);
    mode = 2'd1; run_samples(12);

    phase = "R12 counter clear mid frame";
    mode = 2'd3; fnum_en = 1; dsync_en = 1;
    run_samples(7);
    @(negedge clk); cnt_rst = 1;
    idle(3);
    run_samples(1);
    cnt_rst = 0;
    run_samples(30);

    phase = "R7 R3 stop mid word then restart";
    run_samples(3);
    idle(5);
    @(negedge clk); stop_cmd = 1; start_cmd = 1;
    @(negedge clk); stop_cmd = 0; start_cmd = 0;
    run_samples(3);
    @(negedge clk); start_cmd = 1;
    run_samples(20);
    start_cmd = 0;

    phase = "R1 interface dropped mid stream";
    if_en = 0;
    run_samples(10);
    if_en = 1;
    run_samples(6);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule